// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on one byte that holds two packed BCD digits. It can add, subtract or negate, and it always folds an incoming extend bit into the operation. The extend bit acts as a carry for add and as a borrow for subtract and negate. A start strobe captures the operands. One clock later a done pulse appears, together with the registered BCD result and a new set of condition flags.

The zero flag is sticky. A caller that walks a multi-byte decimal number one byte at a time feeds the previous zero output back as the zero input. The final zero output is then set only if every byte of the chain came out zero.

An operand-form bit says whether the operands came from a register pair or from a predecrement memory pair. The unit does not act on it. The bit is captured with the operands and returned with the result, so the surrounding sequencer can route the write-back.

Top module: `bcd_byte_unit`

## Requirements
- R1: While reset is held, and until the first start after reset, `result_o`, `x_o`, `n_o`, `z_o`, `v_o`, `c_o`, `done_o` and `form_o` are all 0.
- R2: With `op_i` = 2'b00 (add) and both operands made of digits 0..9, the result is the BCD encoding of (dst + src + x_i) mod 100. The upper digit is in bits 7:4 and the lower digit in bits 3:0.
- R3: With `op_i` = 2'b01 (subtract) and valid digits, the result is the BCD encoding of (dst - src - x_i) mod 100.
- R4: With `op_i[1]` = 1 (negate, codes 2'b10 and 2'b11), the result is the BCD encoding of (0 - dst - x_i) mod 100, and `src_i` has no effect on any output.
- R5: `c_o` and `x_o` both equal the decimal carry out of the upper digit (add) or the decimal borrow out of it (subtract and negate).
- R6: `z_o` becomes 0 when the result is nonzero and takes the value of `z_i` when the result is zero.
- R7: `done_o` is 1 in exactly the cycle after each cycle with `start_i` high. Starts on consecutive cycles are all accepted.
- R8: In cycles without `start_i`, every result and flag output keeps its value, whatever the other inputs do.
- R9: `form_o` returns the `form_i` value that was sampled with the start strobe.
- R10: `n_o` equals bit 7 of the result and `v_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the unit releases it synchronously |
| start_i | input | 1 | Capture the operands and run the operation |
| op_i | input | 2 | 00 add, 01 subtract, 1x negate |
| dst_i | input | 8 | Destination operand, two packed BCD digits |
| src_i | input | 8 | Source operand, two packed BCD digits |
| x_i | input | 1 | Incoming extend (carry/borrow) bit |
| z_i | input | 1 | Incoming zero flag for chained operation |
| form_i | input | 1 | Operand form: 0 register pair, 1 predecrement memory pair |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | BCD result |
| x_o | output | 1 | Extend flag out |
| n_o | output | 1 | Negative flag (result bit 7) |
| z_o | output | 1 | Sticky zero flag |
| v_o | output | 1 | Overflow flag, held at 0 |
| c_o | output | 1 | Carry/borrow flag |
| form_o | output | 1 | Captured operand form |

## Verification
The digit-level assertion only applies when both of its incoming digits are 0 to 9, because a byte with a digit above 9 has no defined decimal meaning. The other properties assume that `start_i`, `op_i` and the operands are known at every sampled edge once reset has been released. The stimulus stays inside these limits:
- Every operation is driven with valid digit pairs, covering all 100×100 pairs for add and subtract with both extend values.
- Digits above 9 appear only on idle cycles and on the source operand of negate, which the unit must ignore.
- All inputs change on the falling clock edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [1:0] {
    BCD_ADD  = 2'b00,
    BCD_SUB  = 2'b01,
    BCD_NEG  = 2'b10,
    BCD_NEG2 = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } bcd_flags_t;

endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);

  localparam logic [DW:0]   MAXD = (DW+1)'(9);
  localparam logic [DW-1:0] ADJ  = DW'(6);

  logic [DW:0] raw;

  always_comb begin
    if (!sub_i) begin
      raw = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
      if (raw > MAXD) begin
        sum_o  = raw[DW-1:0] + ADJ;
        cout_o = 1'b1;
      end else begin
        sum_o  = raw[DW-1:0];
        cout_o = 1'b0;
      end
    end else begin
      raw = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
      if (raw[DW]) begin
        sum_o  = raw[DW-1:0] - ADJ;
        cout_o = 1'b1;
      end else begin
        sum_o  = raw[DW-1:0];
        cout_o = 1'b0;
      end
    end
    if ({1'b0, a_i} <= MAXD && {1'b0, b_i} <= MAXD)
      AST_DIGIT_VALID: assert ({1'b0, sum_o} <= MAXD); // R2
  end

endmodule

// File: rtl/bcd_byte_core.sv
module bcd_byte_core
  import bcd_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic [4*NDIG-1:0] dst_i,
  input  logic [4*NDIG-1:0] src_i,
  input  logic              x_i,
  input  bcd_op_e           op_i,
  output logic [4*NDIG-1:0] res_o,
  output logic              carry_o
);

  localparam int W = 4 * NDIG;

  logic [W-1:0]  lhs;
  logic [W-1:0]  rhs;
  logic          is_sub;
  logic [NDIG:0] chain;

  always_comb begin
    is_sub = (op_i != BCD_ADD);
    if (op_i == BCD_NEG || op_i == BCD_NEG2) begin
      lhs = '0;
      rhs = dst_i;
    end else begin
      lhs = dst_i;
      rhs = src_i;
    end
  end

  assign chain[0] = x_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit #(.DW(4)) dig_i (
      .a_i   (lhs[4*g +: 4]),
      .b_i   (rhs[4*g +: 4]),
      .cin_i (chain[g]),
      .sub_i (is_sub),
      .sum_o (res_o[4*g +: 4]),
      .cout_o(chain[g+1])
    );
  end

  assign carry_o = chain[NDIG];

endmodule

// File: rtl/bcd_byte_unit.sv
module bcd_byte_unit
  import bcd_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [4*NDIG-1:0] dst_i,
  input  logic [4*NDIG-1:0] src_i,
  input  logic              x_i,
  input  logic              z_i,
  input  logic              form_i,
  output logic              done_o,
  output logic [4*NDIG-1:0] result_o,
  output logic              x_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              form_o
);

  localparam int W = 4 * NDIG;

  logic         rst_sn;
  logic [W-1:0] core_res;
  logic         core_carry;

  logic [W-1:0] res_q,   res_d;
  bcd_flags_t   flags_q, flags_d;
  logic         done_q,  done_d;
  logic         form_q,  form_d;

  bcd_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sn)
  );

  bcd_byte_core #(.NDIG(NDIG)) core_i (
    .dst_i  (dst_i),
    .src_i  (src_i),
    .x_i    (x_i),
    .op_i   (bcd_op_e'(op_i)),
    .res_o  (core_res),
    .carry_o(core_carry)
  );

  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    form_d  = form_q;
    done_d  = start_i;
    if (start_i) begin
      res_d     = core_res;
      form_d    = form_i;
      flags_d.c = core_carry;
      flags_d.x = core_carry;
      flags_d.n = core_res[W-1];
      flags_d.v = 1'b0;
      flags_d.z = z_i & ~(|core_res);
    end
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      res_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      form_q  <= 1'b0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
      done_q  <= done_d;
      form_q  <= form_d;
    end
  end

  assign result_o = res_q;
  assign x_o      = flags_q.x;
  assign n_o      = flags_q.n;
  assign z_o      = flags_q.z;
  assign v_o      = flags_q.v;
  assign c_o      = flags_q.c;
  assign done_o   = done_q;
  assign form_o   = form_q;

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_sn)
    start_i |=> done_o); // R7
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !start_i |=> !done_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !start_i |=> ($stable(result_o) && $stable(c_o) && $stable(z_o) && $stable(x_o))); // R8
  AST_XC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_sn)
    x_o == c_o); // R5
  AST_Z_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (start_i && !z_i) |=> !z_o); // R6
  AST_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (start_i && op_i[1] && dst_i == '0 && !x_i) |=> (result_o == '0 && !c_o)); // R4

endmodule

// File: tb/bcd_byte_unit_tb_top.sv
module bcd_byte_unit_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [1:0] op_i;
  logic [7:0] dst_i, src_i;
  logic       x_i, z_i, form_i;
  logic       done_o;
  logic [7:0] result_o;
  logic       x_o, n_o, z_o, v_o, c_o, form_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] m_res  = 8'h00;
  logic       m_c    = 1'b0;
  logic       m_z    = 1'b0;
  logic       m_done = 1'b0;
  logic       m_form = 1'b0;
  string      m_tag  = "R1";

  always #4 clk_i = ~clk_i;

  bcd_byte_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .x_i(x_i), .z_i(z_i), .form_i(form_i),
    .done_o(done_o), .result_o(result_o), .x_o(x_o), .n_o(n_o),
    .z_o(z_o), .v_o(v_o), .c_o(c_o), .form_o(form_o)
  );

  function automatic int bcd_val(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    logic [3:0] hi, lo;
    hi = 4'((v / 10) % 10);
    lo = 4'(v % 10);
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R7 done_o", int'(done_o), int'(m_done));
    chk({m_tag, " result_o"}, int'(result_o), int'(m_res));
    chk("R5 c_o", int'(c_o), int'(m_c));
    chk("R5 x_o", int'(x_o), int'(m_c));
    chk("R6 z_o", int'(z_o), int'(m_z));
    chk("R10 n_o", int'(n_o), int'(m_res[7]));
    chk("R10 v_o", int'(v_o), 0);
    chk("R9 form_o", int'(form_o), int'(m_form));
  endtask

  // one cycle: check what the previous cycle produced, then drive new inputs
  task automatic cyc(input logic st, input logic [1:0] op, input logic [7:0] d,
                     input logic [7:0] s, input logic x, input logic z, input logic f);
    int t;
    @(negedge clk_i);
    compare_all();
    start_i = st; op_i = op; dst_i = d; src_i = s; x_i = x; z_i = z; form_i = f;
    m_done = st;
    if (st) begin
      if (op == 2'b00) begin
        t = bcd_val(d) + bcd_val(s) + int'(x);
        m_tag = "R2";
      end else if (op == 2'b01) begin
        t = bcd_val(d) - bcd_val(s) - int'(x);
        m_tag = "R3";
      end else begin
        t = 0 - bcd_val(d) - int'(x);
        m_tag = "R4";
      end
      m_c = (t >= 100) || (t < 0);
      m_res = to_bcd((t + 100) % 100);
      m_z = z & (m_res == 8'h00);
      m_form = f;
    end else begin
      m_tag = "R8";
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int k;
    rst_ni = 1'b0; start_i = 1'b0; op_i = 2'b00; dst_i = 8'h00; src_i = 8'h00;
    x_i = 1'b0; z_i = 1'b0; form_i = 1'b0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk_i);
      compare_all();
    end
    rst_ni = 1'b1;
    repeat (4) cyc(1'b0, 2'b00, 8'h99, 8'h99, 1'b1, 1'b1, 1'b1);

    // R4: negate with zero destination and no borrow gives zero, no borrow
    cyc(1'b1, 2'b10, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 2'b11, 8'h00, 8'hAB, 1'b1, 1'b1, 1'b1);

    // R6: two-byte chain 0199 + 9801 = 0000 with carry, zero stays set
    cyc(1'b1, 2'b00, 8'h99, 8'h01, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 2'b00, 8'h01, 8'h98, 1'b1, 1'b1, 1'b0);
    // R6: chain where a low byte is nonzero clears zero for good
    cyc(1'b1, 2'b01, 8'h50, 8'h49, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 2'b01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    // R2 R3 R5: every valid digit pair, both extend values, add and subtract
    k = 0;
    for (int x = 0; x < 2; x++) begin
      for (int d = 0; d < 100; d++) begin
        for (int s = 0; s < 100; s++) begin
          cyc(1'b1, 2'b00, to_bcd(d), to_bcd(s), x[0], 1'(((d ^ s) >> 1) & 1), 1'(s & 1));
          cyc(1'b1, 2'b01, to_bcd(d), to_bcd(s), x[0], 1'((d ^ s ^ 1) & 1), 1'(d & 1));
          k++;
          if (k % 97 == 0)
            cyc(1'b0, 2'(k & 3), 8'(k), 8'(k * 7), 1'(k & 1), 1'(k & 2), 1'(k & 4)); // R8
        end
      end
    end

    // R4: negate over every destination, source carries invalid digits
    for (int x = 0; x < 2; x++) begin
      for (int d = 0; d < 100; d++) begin
        cyc(1'b1, {1'b1, 1'(d & 1)}, to_bcd(d), 8'(d * 37 + 170), x[0], 1'b1, 1'(d & 1));
      end
    end

    // R8: long idle with toggling inputs
    for (int i = 0; i < 8; i++)
      cyc(1'b0, 2'(i), 8'(i * 29), 8'(255 - i), 1'(i & 1), 1'(i & 1), 1'(i & 1));

    @(negedge clk_i);
    compare_all();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule